// File: doc/BRIEF.md
# Universal Serial Shift Datapath

The block is the data path of a small general-purpose serial port. An 8-bit shift register moves one place toward its top bit on each shift trigger and takes the serial data input into bit 0. A host port loads the register, and the host reads the register and a separate receive buffer at any time. A 2-bit select picks the shift trigger: a software strobe, a timer compare pulse, or an edge of an external serial clock. For the external clock, a second select bit chooses whether data is sampled on the rising edge or on the falling edge.

The top bit of the register drives the serial output through an output latch. The latch keeps output changes away from the sampling edge. A 4-bit edge counter marks the end of each byte. When it wraps, the register contents are copied into the read-only buffer and a sticky done flag is raised. The host clears the flag by writing a one to it. The external clock and data inputs each pass through a two-flop synchronizer before use.

Top module: `usi_shift_core`

## Requirements
- R1: When a host write (`wr_en`=1) and a shift trigger fall in the same cycle, the register takes `wr_data` and does not shift.
- R2: Each shift moves the register one place toward bit 7 and puts the synchronized serial input into bit 0.
- R3: `clk_sel` selects the shift trigger. 2'b00 selects `sw_strobe` and 2'b01 selects `tmr_match`. 2'b10 selects the external clock with sampling on its rising edge. 2'b11 selects the external clock with sampling on its falling edge. Triggers that are not selected have no effect on the register.
- R4: With an internal trigger (`clk_sel[1]`=0), the output latch is always open. `ser_out` equals register bit 7, so a host write that changes bit 7 appears on `ser_out` in the cycle after the write.
- R5: With an external clock, the latch is open only while the synchronized clock is at its level before the sampling edge. While the clock is at the other level, `ser_out` holds, so the output changes only on the non-sampling edge.
- R6: The counter advances by 1 on every synchronized external clock edge (rising or falling) and by 2 on every internal trigger. A byte is therefore 16 external edges or 8 internal shifts. When the counter wraps, the buffer takes the register's new value. At all other times the buffer is unchanged.
- R7: `done_flag` is set when the counter wraps and stays set until `done_clr`=1 is applied. If a wrap and a clear fall in the same cycle, the set wins.
- R8: After reset, the register, the buffer, the counter, `done_flag` and `ser_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the shift register |
| wr_data | input | 8 | Host write data |
| rd_shift | output | 8 | Shift register contents |
| rd_buf | output | 8 | Receive buffer contents (read only) |
| clk_sel | input | 2 | Shift trigger select |
| sw_strobe | input | 1 | Software shift strobe, one cycle |
| tmr_match | input | 1 | Timer compare pulse, one cycle |
| ext_sclk | input | 1 | External serial clock (asynchronous) |
| ext_din | input | 1 | Serial data input (asynchronous) |
| done_clr | input | 1 | Writing one clears the done flag |
| done_flag | output | 1 | Sticky byte-complete flag |
| ser_out | output | 1 | Serial data output from the latch |

## Verification
Whole bytes are shifted in under all four trigger selections. The byte values include alternating patterns, a single set bit, and all ones. Together they show the shift direction, the bit 0 entry point, and correct edge counting for both sampling polarities. A byte stopped one internal shift short of completion separates a correct wrap point from an early one. Pulses on triggers that are not selected, and on the external clock while an internal trigger is selected, show that selection blocks those triggers. Host writes made while the latch is open and while it is closed show the difference between the transparent and holding latch states. A host write made together with a strobe shows that the write has priority.

// File: rtl/usi_shift_core.sv
module usi_shift_core #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_shift,
  output logic [W-1:0] rd_buf,
  input  logic [1:0]   clk_sel,
  input  logic         sw_strobe,
  input  logic         tmr_match,
  input  logic         ext_sclk,
  input  logic         ext_din,
  input  logic         done_clr,
  output logic         done_flag,
  output logic         ser_out
);
  logic [2:0]    sclk_sy;
  logic [1:0]    din_sy;
  logic [W-1:0]  sreg, sreg_nxt, buf_q;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          cnt_wrap, held, done_q;

  wire sclk_lvl = sclk_sy[1];
  wire rise     = sclk_lvl & ~sclk_sy[2];
  wire fall     = ~sclk_lvl & sclk_sy[2];
  wire ext_mode = clk_sel[1];
  wire smp_fall = clk_sel[0];
  wire ext_edge = ext_mode & (rise | fall);
  wire int_tick = ~ext_mode & (smp_fall ? tmr_match : sw_strobe);
  wire do_shift = ext_mode ? (smp_fall ? fall : rise) : int_tick;
  wire latch_open = ~ext_mode | (sclk_lvl == smp_fall);

  wire [CW-1:0] cnt_step = ext_edge ? CW'(1) : (int_tick ? CW'(2) : CW'(0));

  assign {cnt_wrap, cnt_nxt} = {1'b0, cnt} + {1'b0, cnt_step};

  always_comb begin
    sreg_nxt = sreg;
    if (wr_en)         sreg_nxt = wr_data;
    else if (do_shift) sreg_nxt = {sreg[W-2:0], din_sy[1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      din_sy  <= '0;
      sreg    <= '0;
      buf_q   <= '0;
      cnt     <= '0;
      held    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], ext_sclk};
      din_sy  <= {din_sy[0], ext_din};
      sreg    <= sreg_nxt;
      cnt     <= cnt_nxt;
      if (cnt_wrap)   buf_q <= sreg_nxt;
      if (latch_open) held  <= sreg[W-1];
      if (cnt_wrap)      done_q <= 1'b1;
      else if (done_clr) done_q <= 1'b0;
    end
  end

  assign rd_shift  = sreg;
  assign rd_buf    = buf_q;
  assign done_flag = done_q;
  assign ser_out   = latch_open ? sreg[W-1] : held;
endmodule

// File: rtl/usi_shift_core_chk.sv
module usi_shift_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] rd_shift,
  input logic [W-1:0] rd_buf,
  input logic [1:0]   clk_sel,
  input logic         done_clr,
  input logic         done_flag,
  input logic         ser_out,
  input logic         do_shift,
  input logic         cnt_wrap,
  input logic         latch_open
);
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> rd_shift == $past(wr_data)); // R1
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n) (do_shift && !wr_en) |=> rd_shift[W-1:1] == $past(rd_shift[W-2:0])); // R2
  AST_INT_OPEN: assert property (@(posedge clk) disable iff (!rst_n) !clk_sel[1] |-> ser_out == rd_shift[W-1]); // R4
  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !latch_open |-> $stable(ser_out)); // R5
  AST_BUF_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !cnt_wrap |=> $stable(rd_buf)); // R6
  AST_BUF_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cnt_wrap |=> rd_buf == rd_shift); // R6
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n) cnt_wrap |=> done_flag); // R7
  AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n) (done_clr && !cnt_wrap) |=> !done_flag); // R7
endmodule

bind usi_shift_core usi_shift_core_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_shift(rd_shift), .rd_buf(rd_buf), .clk_sel(clk_sel),
  .done_clr(done_clr), .done_flag(done_flag), .ser_out(ser_out),
  .do_shift(do_shift), .cnt_wrap(cnt_wrap), .latch_open(latch_open)
);

// File: tb/tb_usi_shift_core.sv
module tb_usi_shift_core;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, sw_strobe = 0, tmr_match = 0, ext_sclk = 0, ext_din = 0, done_clr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] clk_sel = 0;
  logic [7:0] rd_shift, rd_buf;
  logic       done_flag, ser_out;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usi_shift_core dut (.*);

  localparam logic [9:0] VEC [6] = '{
    {2'b00, 8'hA5}, {2'b01, 8'h3C}, {2'b10, 8'hC3},
    {2'b11, 8'h5A}, {2'b10, 8'h01}, {2'b00, 8'hFF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_int(input logic [1:0] mode);
    if (mode == 2'b00) sw_strobe = 1; else tmr_match = 1;
    cyc(1);
    sw_strobe = 0; tmr_match = 0;
  endtask

  task automatic send_byte(input logic [1:0] mode, input logic [7:0] b);
    logic idle;
    idle = (mode == 2'b11);
    clk_sel = 2'b00; ext_sclk = idle; cyc(6);
    clk_sel = mode;
    for (int i = 7; i >= 0; i--) begin
      ext_din = b[i];
      cyc(4);
      if (mode[1]) begin
        ext_sclk = ~idle; cyc(4);
        ext_sclk = idle;  cyc(4);
      end else begin
        pulse_int(mode); cyc(1);
      end
    end
    cyc(6);
  endtask

  task automatic do_reset;
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(2); rst_n = 1; cyc(1);
    chk("R8 shift reset", rd_shift, 8'h00);
    chk("R8 buf reset", rd_buf, 8'h00);
    chk("R8 flag reset", {7'b0, done_flag}, 8'h00);
    chk("R8 out reset", {7'b0, ser_out}, 8'h00);

    for (int v = 0; v < 6; v++) begin
      send_byte(VEC[v][9:8], VEC[v][7:0]);
      chk("R2 shifted byte", rd_shift, VEC[v][7:0]);
      chk("R6 buffer load", rd_buf, VEC[v][7:0]);
      chk("R7 done set", {7'b0, done_flag}, 8'h01);
      chk("R4/R5 serial out", {7'b0, ser_out}, {7'b0, VEC[v][7]});
      done_clr = 1; cyc(1); done_clr = 0;
      chk("R7 done cleared", {7'b0, done_flag}, 8'h00);
    end

    // R6: seven shifts do not complete, eighth does
    clk_sel = 2'b00; ext_din = 0; cyc(2);
    for (int i = 0; i < 7; i++) begin pulse_int(2'b00); cyc(1); end
    chk("R6 no early flag", {7'b0, done_flag}, 8'h00);
    chk("R6 buf held", rd_buf, 8'hFF);
    chk("R2 partial shift", rd_shift, 8'h80);
    pulse_int(2'b00); cyc(1);
    chk("R6 eighth completes", rd_buf, 8'h00);
    chk("R7 flag on eighth", {7'b0, done_flag}, 8'h01);
    done_clr = 1; cyc(1); done_clr = 0;

    // R3: unselected triggers ignored
    wr_data = 8'h96; wr_en = 1; cyc(1); wr_en = 0; ext_din = 1; cyc(3);
    clk_sel = 2'b00; pulse_int(2'b01); cyc(1);
    chk("R3 timer ignored in strobe mode", rd_shift, 8'h96);
    clk_sel = 2'b01; pulse_int(2'b00); cyc(1);
    chk("R3 strobe ignored in timer mode", rd_shift, 8'h96);
    clk_sel = 2'b00; ext_sclk = 1; cyc(6); ext_sclk = 0; cyc(6);
    chk("R3 ext clock ignored in strobe mode", rd_shift, 8'h96);

    // R4: transparent latch in internal mode
    wr_data = 8'h80; wr_en = 1; cyc(1); wr_en = 0;
    chk("R4 write bit7 high visible", {7'b0, ser_out}, 8'h01);
    wr_data = 8'h00; wr_en = 1; cyc(1); wr_en = 0;
    chk("R4 write bit7 low visible", {7'b0, ser_out}, 8'h00);

    // R1: write beats strobe
    ext_din = 1; cyc(3);
    wr_data = 8'h5A; wr_en = 1; sw_strobe = 1; cyc(1); wr_en = 0; sw_strobe = 0;
    chk("R1 write wins over shift", rd_shift, 8'h5A);

    do_reset();
    chk("R8 shift after reset", rd_shift, 8'h00);

    // R5: external latch holds during second half
    clk_sel = 2'b10; ext_din = 0; ext_sclk = 0; cyc(4);
    wr_data = 8'h80; wr_en = 1; cyc(1); wr_en = 0;
    chk("R5 open while clock low", {7'b0, ser_out}, 8'h01);
    ext_sclk = 1; cyc(5);
    chk("R2 ext rising shift", rd_shift, 8'h00);
    chk("R5 held after sampling edge", {7'b0, ser_out}, 8'h01);
    wr_data = 8'h40; wr_en = 1; cyc(1); wr_en = 0; cyc(1);
    chk("R5 write hidden while closed", {7'b0, ser_out}, 8'h01);
    ext_sclk = 0; cyc(5);
    chk("R5 updates on falling edge", {7'b0, ser_out}, 8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule